// File: doc/BRIEF.md
# Dual signed 16-bit multiply-accumulate unit

This block is a datapath slice for a processor's multiply pipeline. It splits two 32-bit operands into signed 16-bit halves and forms two signed products: low half times low half, and high half times high half. It then combines the two products with an optional 32-bit accumulator. In add mode the two products are summed. In subtract mode the high product is taken from the low product. Before the multiply, the halves of the second operand can be exchanged.

The result is the low 32 bits of the exact answer. It is registered one cycle after the input strobe and comes with an output-valid pulse. A sticky saturation flag records whether the exact answer did not fit in a signed 32-bit word. That overflow test runs once, on the full three-term sum. It is never split into two chained 32-bit checks, so a pair of products can overflow on their own while the accumulator brings the total back into range, and the flag stays clear. A dedicated input clears the flag.

Top module: `dual_mac16`

## Requirements
- R1: The two products are signed: op_a[15:0]*op_b[15:0] (low pair) and op_a[31:16]*op_b[31:16] (high pair). Each half is read as a two's-complement number.
- R2: With sub_sel=0, res is the low 32 bits of low product + high product, plus acc when acc_en=1.
- R3: A valid operation sets q_flag when the exact sum of all its terms lies outside [-2^31, 2^31-1]. The test is made once, over the complete sum, so 0x80008000, 0x80008000 with acc 0xFFFFFFFF gives 0x7FFFFFFF and leaves q_flag clear.
- R4: With sub_sel=1, res is the low 32 bits of (low product - high product), plus acc when acc_en=1. q_flag is set only if that accumulation leaves the signed 32-bit range. With acc_en=0 a subtraction never sets it.
- R5: With acc_en=0 the value on acc has no effect on res or q_flag.
- R6: With swap_b=1, op_b is replaced by {op_b[15:0], op_b[31:16]} before multiplying.
- R7: res and res_valid update on the clock edge after in_valid is high. res_valid is high for exactly that one cycle. res holds its value while in_valid is low.
- R8: q_flag is sticky. Once set, it stays set through any number of later operations, whether they overflow or not.
- R9: q_clear=1 makes q_flag 0 after the next edge. This takes priority over an overflow in the same cycle.
- R10: Synchronous active-low reset drives res to 0, res_valid to 0 and q_flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 32 | First operand, two signed halves |
| op_b | input | 32 | Second operand, two signed halves |
| acc | input | 32 | Signed accumulator term |
| acc_en | input | 1 | Add acc into the result |
| sub_sel | input | 1 | 1: low product minus high product |
| swap_b | input | 1 | Exchange the halves of op_b |
| q_clear | input | 1 | Clear the sticky flag |
| res | output | 32 | Low 32 bits of the exact result |
| res_valid | output | 1 | Result strobe, one cycle after in_valid |
| q_flag | output | 1 | Sticky overflow flag |

## Verification
The bench targets the case where both products are 2^30 and the accumulator is -1. A design that checks overflow in two chained steps would raise the flag there. It also covers the negative edge, where a sum of exactly -2^31 must leave the flag clear and -2^31-1 must set it; an off-by-one range test would get one of these wrong. Subtract cases show the difference of extreme products staying in range, and show an accumulator pushing it over. Swap and accumulate-disable vectors use values whose results change if the halves are paired wrongly or if acc leaks in. Directed tests show a set flag surviving a clean operation and a clear winning over a simultaneous overflow.

// File: rtl/dmac_pkg.sv
// Package: shared widths and the control bundle of the dual MAC.
// Assumes operands are two equal signed halves packed in one word.
package dmac_pkg;
    localparam int HALF_W = 16;
    localparam int DATA_W = 2 * HALF_W;
    // two guard bits keep a sum of three 32-bit-range terms exact
    localparam int SUM_W  = DATA_W + 2;

    typedef struct packed {
        logic acc_en;
        logic sub_sel;
        logic swap_b;
    } dmac_ctrl_t;
endpackage

// File: rtl/dmac_prod.sv
// Product stage: forms the low-pair and high-pair signed products.
// Assumes the swap select exchanges the halves of operand B only.
module dmac_prod #(
    parameter int HALF_W = 16,
    localparam int DATA_W = 2 * HALF_W
) (
    input  logic [DATA_W-1:0]        op_a,
    input  logic [DATA_W-1:0]        op_b,
    input  logic                     swap_b,
    output logic signed [DATA_W-1:0] prod_lo,
    output logic signed [DATA_W-1:0] prod_hi
);
    logic [DATA_W-1:0]        b_eff;
    logic signed [DATA_W-1:0] prod [2];

    // Pick operand B as given or with its halves exchanged.
    always_comb begin
        b_eff = swap_b ? {op_b[HALF_W-1:0], op_b[DATA_W-1:HALF_W]} : op_b;
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic signed [HALF_W-1:0] ha;
        logic signed [HALF_W-1:0] hb;
        // Signed multiply of one half pair into a full-width product.
        always_comb begin
            ha      = op_a[g*HALF_W +: HALF_W];
            hb      = b_eff[g*HALF_W +: HALF_W];
            prod[g] = DATA_W'(ha) * DATA_W'(hb);
        end
    end

    assign prod_lo = prod[0];
    assign prod_hi = prod[1];
endmodule

// File: rtl/dmac_comb.sv
// Combine stage: exact sum or difference of products plus optional
// accumulator, with one overflow test over the whole sum.
// Assumes products fit in DATA_W signed bits; SUM_W >= DATA_W + 2.
module dmac_comb #(
    parameter int DATA_W = 32,
    parameter int SUM_W  = DATA_W + 2,
    localparam int EXT_W = SUM_W - DATA_W
) (
    input  logic signed [DATA_W-1:0] prod_lo,
    input  logic signed [DATA_W-1:0] prod_hi,
    input  logic [DATA_W-1:0]        acc,
    input  logic                     acc_en,
    input  logic                     sub_sel,
    output logic [DATA_W-1:0]        sum_lo,
    output logic                     ovf
);
    logic signed [SUM_W-1:0] t_lo;
    logic signed [SUM_W-1:0] t_hi;
    logic signed [SUM_W-1:0] t_acc;
    logic signed [SUM_W-1:0] exact;
    logic [EXT_W:0]          top_bits;

    // Sign-extend every term to the exact-sum width.
    always_comb begin
        t_lo  = {{EXT_W{prod_lo[DATA_W-1]}}, prod_lo};
        t_hi  = {{EXT_W{prod_hi[DATA_W-1]}}, prod_hi};
        t_acc = acc_en ? {{EXT_W{acc[DATA_W-1]}}, acc} : '0;
    end

    // Form the exact three-term sum in one step.
    always_comb begin
        exact = (sub_sel ? (t_lo - t_hi) : (t_lo + t_hi)) + t_acc;
    end

    // Result is the low word; overflow when the bits above do not extend bit 31.
    always_comb begin
        sum_lo   = exact[DATA_W-1:0];
        top_bits = exact[SUM_W-1:DATA_W-1];
        ovf      = ~((&top_bits) | ~(|top_bits));
    end

    // Check that a subtraction without accumulation never overflows.
    always_comb begin
        // R4
        if (sub_sel && !acc_en) begin
            sub_no_ovf_chk: assert (!ovf);
        end
    end
endmodule

// File: rtl/dmac_qflag.sv
// Sticky overflow flag: set by an overflowing operation, cleared only
// by reset or the clear input, with clear taking priority.
module dmac_qflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_q,
    input  logic clr_q,
    output logic q
);
    // Hold, set or clear the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (clr_q) q <= 1'b0;
        else if (set_q) q <= 1'b1;
    end

    // R8
    q_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr_q) |=> q);
    // R9
    q_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |=> !q);
endmodule

// File: rtl/dual_mac16.sv
// Top: dual signed 16x16 multiply with add/subtract combine, optional
// accumulate, registered result and a sticky overflow flag.
// Assumes one operation per in_valid cycle; result appears one edge later.
module dual_mac16
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] acc,
    input  logic              acc_en,
    input  logic              sub_sel,
    input  logic              swap_b,
    input  logic              q_clear,
    output logic [DATA_W-1:0] res,
    output logic              res_valid,
    output logic              q_flag
);
    dmac_ctrl_t               ctrl;
    logic signed [DATA_W-1:0] prod_lo;
    logic signed [DATA_W-1:0] prod_hi;
    logic [DATA_W-1:0]        sum_lo;
    logic                     ovf;

    // Bundle the mode inputs.
    always_comb begin
        ctrl = '{acc_en: acc_en, sub_sel: sub_sel, swap_b: swap_b};
    end

    dmac_prod #(.HALF_W(HALF_W)) prod_i (
        .op_a    (op_a),
        .op_b    (op_b),
        .swap_b  (ctrl.swap_b),
        .prod_lo (prod_lo),
        .prod_hi (prod_hi)
    );

    dmac_comb #(.DATA_W(DATA_W), .SUM_W(SUM_W)) comb_i (
        .prod_lo (prod_lo),
        .prod_hi (prod_hi),
        .acc     (acc),
        .acc_en  (ctrl.acc_en),
        .sub_sel (ctrl.sub_sel),
        .sum_lo  (sum_lo),
        .ovf     (ovf)
    );

    dmac_qflag qflag_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_q (in_valid && ovf),
        .clr_q (q_clear),
        .q     (q_flag)
    );

    // Register the result on a valid operation; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        res <= '0;
        else if (in_valid) res <= sum_lo;
    end

    // Output strobe follows the input strobe by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= in_valid;
    end

    // R7
    res_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    // R7
    res_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    // R7
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res));
    // R3
    q_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ovf && !q_clear) |=> q_flag);
endmodule

// File: tb/dual_mac16_tb_top.sv
module dual_mac16_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [15:0] tag;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] acc;
        logic        en;
        logic        sub;
        logic        swp;
        logic [31:0] res;
        logic        ovf;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [0:NV-1] = '{
        '{"R2", 32'h00030002, 32'h00050004, 32'h00000010, 1'b1, 1'b0, 1'b0, 32'h00000027, 1'b0},
        '{"R3", 32'h80008000, 32'h80008000, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 32'h7FFFFFFF, 1'b0},
        '{"R5", 32'h80008000, 32'h80008000, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0, 32'h80000000, 1'b1},
        '{"R3", 32'h80008000, 32'h80008000, 32'h00000000, 1'b1, 1'b0, 1'b0, 32'h80000000, 1'b1},
        '{"R4", 32'h80008000, 32'h80008000, 32'h7FFFFFFF, 1'b1, 1'b1, 1'b0, 32'h7FFFFFFF, 1'b0},
        '{"R4", 32'h7FFF8000, 32'h80008000, 32'h12345678, 1'b0, 1'b1, 1'b0, 32'h7FFF8000, 1'b0},
        '{"R4", 32'h7FFF8000, 32'h80008000, 32'h00008000, 1'b1, 1'b1, 1'b0, 32'h80000000, 1'b1},
        '{"R6", 32'h00020003, 32'h00070005, 32'h00000000, 1'b0, 1'b0, 1'b1, 32'h0000001F, 1'b0},
        '{"R1", 32'hFFFF0001, 32'h00030004, 32'hFFFFFFF0, 1'b1, 1'b0, 1'b0, 32'hFFFFFFF1, 1'b0},
        '{"R3", 32'h80008000, 32'h7FFF7FFF, 32'hFFFF0000, 1'b1, 1'b0, 1'b0, 32'h80000000, 1'b0},
        '{"R3", 32'h80008000, 32'h7FFF7FFF, 32'hFFFEFFFF, 1'b1, 1'b0, 1'b0, 32'h7FFFFFFF, 1'b1},
        '{"R6", 32'h00010002, 32'h00030004, 32'h00000005, 1'b1, 1'b1, 1'b1, 32'h00000007, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] acc = '0;
    logic        acc_en = 1'b0;
    logic        sub_sel = 1'b0;
    logic        swap_b = 1'b0;
    logic        q_clear = 1'b0;
    logic [31:0] res;
    logic        res_valid;
    logic        q_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    dual_mac16 dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .acc       (acc),
        .acc_en    (acc_en),
        .sub_sel   (sub_sel),
        .swap_b    (swap_b),
        .q_clear   (q_clear),
        .res       (res),
        .res_valid (res_valid),
        .q_flag    (q_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            finish_run();
        end
    end

    // Drive one operation for one cycle; outputs are sampled at the following negedge.
    task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                         input logic en, input logic sub, input logic swp, input logic clr);
        @(negedge clk);
        op_a = a; op_b = b; acc = c;
        acc_en = en; sub_sel = sub; swap_b = swp;
        q_clear = clr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; q_clear = 1'b0;
    endtask

    task automatic clear_q();
        @(negedge clk);
        q_clear = 1'b1;
        @(negedge clk);
        q_clear = 1'b0;
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 res", res, 32'h0);
        chk("R10 res_valid", {31'b0, res_valid}, 32'h0);
        chk("R10 q_flag", {31'b0, q_flag}, 32'h0);
        rst_n = 1'b1;

        // Table of vectors, each starting from a clear flag.
        for (int i = 0; i < NV; i++) begin
            clear_q();
            do_op(VECS[i].a, VECS[i].b, VECS[i].acc, VECS[i].en,
                  VECS[i].sub, VECS[i].swp, 1'b0);
            chk({string'(VECS[i].tag), " res"}, res, VECS[i].res);
            chk({string'(VECS[i].tag), " q_flag"}, {31'b0, q_flag}, {31'b0, VECS[i].ovf});
            chk("R7 res_valid pulse", {31'b0, res_valid}, 32'h1);
        end

        // R7: res holds and res_valid stays low while idle, despite changing inputs.
        @(negedge clk);
        op_a = 32'h00010001; op_b = 32'h00010001; acc = 32'h5;
        @(negedge clk);
        chk("R7 res hold", res, VECS[NV-1].res);
        chk("R7 res_valid idle", {31'b0, res_valid}, 32'h0);

        // R8: a set flag survives a non-overflowing operation.
        clear_q();
        do_op(32'h80008000, 32'h80008000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 set", {31'b0, q_flag}, 32'h1);
        do_op(32'h00030002, 32'h00050004, 32'h10, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 result", res, 32'h00000027);
        chk("R8 sticky", {31'b0, q_flag}, 32'h1);

        // R9: clear wins over an overflow in the same cycle.
        do_op(32'h80008000, 32'h80008000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 clear priority", {31'b0, q_flag}, 32'h0);
        chk("R9 result still written", res, 32'h80000000);

        // R9: clear alone drops a set flag.
        do_op(32'h80008000, 32'h80008000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        clear_q();
        chk("R9 clear alone", {31'b0, q_flag}, 32'h0);

        // R10: reset in mid-run.
        do_op(32'h80008000, 32'h80008000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid-run res", res, 32'h0);
        chk("R10 mid-run q_flag", {31'b0, q_flag}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end
endmodule